// File: doc/BRIEF.md
# Periodic, Alarm and Update Interrupt Controller

This block merges three interrupt sources of a real-time clock onto one active-low request line. It has a 15-bit divider that counts strobes from a 32.768 kHz oscillator. The divider gives a periodic tick, with the rate chosen by a 4-bit code, and it also drives a square-wave output at the same rate. The calendar counter sits outside this block. Each time that counter finishes its once-per-second update, it pulses an input, and the block then compares the current seconds, minutes and hours with three alarm bytes.

Each source sets its own sticky flag, and each flag has an enable mask. The request line goes low while any enabled flag is set. A single read strobe clears all flags together. The flags set whether or not their mask bit is set, so software can poll them with the interrupt disabled.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: While `rst` is high, the next clock edge leaves `flags` at 0, `irq_n` at 1 and `sqw` at 0.
- R2: The divider counts the `osc_en` strobes since reset, modulo 32768. With `rate_sel` = c, where c is 3 to 15, flag bit 0 (periodic) is set on every strobe that brings this count to a multiple of 2^(c-1). Code 3 gives 8192 Hz and code 15 gives 2 Hz. With code 0, bit 0 is never set.
- R3: Code 1 gives the same rate as code 8 (256 Hz, every 128 strobes). Code 2 gives the same rate as code 9 (128 Hz, every 256 strobes).
- R4: When `sqw_en` is 1 and the code is not 0, `sqw` equals bit (e-2) of the strobe count. Here e is the code after the aliasing of R3, so the square wave has the same period as the periodic tick. Otherwise `sqw` is 0.
- R5: On an `upd_done` pulse, flag bit 1 (alarm) is set when each alarm byte either equals its time byte or has bits 7:6 both at 1. An alarm byte with bits 7:6 at 1 is a wildcard that matches any value.
- R6: Every `upd_done` pulse sets flag bit 2 (update ended).
- R7: Flags and `irq_n` change one clock after the event that causes them. `irq_n` is 0 exactly when some flag bit is 1 and the matching `irq_mask` bit was 1 at the same edge.
- R8: `flag_rd` clears all three flags at the next edge. An event in the same cycle as `flag_rd` still leaves its flag set.
- R9: A mask bit at 0 does not stop its flag from being set. It only keeps `irq_n` high.
- R10: Without `upd_done`, the alarm and update flags keep their value, even when the time bytes equal the alarm bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One-cycle strobe at the 32.768 kHz oscillator rate |
| rate_sel | input | 4 | Periodic and square-wave rate code |
| sqw_en | input | 1 | Square-wave output enable |
| irq_mask | input | 3 | Enables: bit 0 periodic, bit 1 alarm, bit 2 update |
| flag_rd | input | 1 | Flag read strobe; clears all flags |
| upd_done | input | 1 | Pulse at the end of each calendar update |
| now_sec | input | 8 | Current seconds byte |
| now_min | input | 8 | Current minutes byte |
| now_hr | input | 8 | Current hours byte |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hr | input | 8 | Alarm hours byte |
| flags | output | 3 | Sticky flags: bit 0 periodic, bit 1 alarm, bit 2 update |
| irq_n | output | 1 | Active-low combined interrupt request |
| sqw | output | 1 | Square-wave output |

## Verification
Every result of this block is due exactly one clock edge after the inputs that cause it. This holds for a strobe that completes a tick period, an update pulse with its compare, a read, and a change of mask or square-wave enable. The bench drives its inputs 1 ns after a rising edge. Its behavioural model takes those inputs at the next edge. The flags, `irq_n` and `sqw` are compared at the following falling edge. The directed checks for rate aliasing, read clearing, masking and wildcards sample 1 ns after the single edge that registers the stimulus.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NUM_SRC  = 3;
  localparam int SRC_PER  = 0;
  localparam int SRC_ALM  = 1;
  localparam int SRC_UPD  = 2;

  // Divider bit that carries the wave for a rate code; codes 1 and 2
  // reuse the taps of codes 8 and 9.
  function automatic int rate_tap(input int code);
    if (code == 1) return 6;
    if (code == 2) return 7;
    return code - 2;
  endfunction
endpackage

// File: rtl/rtc_irq_prescaler.sv
module rtc_irq_prescaler #(
  parameter int DIV_W  = 15,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_en,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              sqw_en,
  output logic              tick_evt,
  output logic              sqw
);
  import rtc_irq_pkg::*;

  localparam int NCODE = 1 << RATE_W;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_nxt;
  logic [NCODE-1:0] evt_vec;
  logic [NCODE-1:0] wave_vec;

  assign cnt_nxt = osc_en ? cnt_q + {{(DIV_W-1){1'b0}}, 1'b1} : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  assign evt_vec[0]  = 1'b0;
  assign wave_vec[0] = 1'b0;

  for (genvar g = 1; g < NCODE; g++) begin : g_tap
    localparam int TAP = rate_tap(g);
    if (TAP >= 1 && TAP < DIV_W) begin : g_ok
      // Tick fires on the strobe that rolls the low TAP+1 bits over.
      assign evt_vec[g]  = &cnt_q[TAP:0];
      assign wave_vec[g] = cnt_nxt[TAP];
    end else begin : g_none
      assign evt_vec[g]  = 1'b0;
      assign wave_vec[g] = 1'b0;
    end
  end

  assign tick_evt = osc_en & evt_vec[rate_sel];

  always_ff @(posedge clk) begin
    if (rst) sqw <= 1'b0;
    else     sqw <= sqw_en & wave_vec[rate_sel];
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int NF = 3,
  parameter int BW = 8
) (
  input  logic [NF-1:0][BW-1:0] alarm_b,
  input  logic [NF-1:0][BW-1:0] now_b,
  output logic                  hit
);
  logic [NF-1:0] fld_ok;

  for (genvar i = 0; i < NF; i++) begin : g_fld
    logic wild;
    assign wild      = &alarm_b[i][BW-1:BW-2];
    assign fld_ok[i] = wild | (alarm_b[i] == now_b[i]);
  end

  assign hit = &fld_ok;
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_evt,
  input  logic [NSRC-1:0] mask,
  input  logic            clr,
  output logic [NSRC-1:0] flags,
  output logic            irq_n
);
  logic [NSRC-1:0] flags_nxt;

  // Clear first, then OR in new events so an event during a read survives.
  assign flags_nxt = (clr ? '0 : flags) | src_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq_n <= 1'b1;
    end else begin
      flags <= flags_nxt;
      irq_n <= ~|(flags_nxt & mask);
    end
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int DIV_W  = 15,
  parameter int RATE_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_en,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              sqw_en,
  input  logic [2:0]        irq_mask,
  input  logic              flag_rd,
  input  logic              upd_done,
  input  logic [BYTE_W-1:0] now_sec,
  input  logic [BYTE_W-1:0] now_min,
  input  logic [BYTE_W-1:0] now_hr,
  input  logic [BYTE_W-1:0] alm_sec,
  input  logic [BYTE_W-1:0] alm_min,
  input  logic [BYTE_W-1:0] alm_hr,
  output logic [2:0]        flags,
  output logic              irq_n,
  output logic              sqw
);
  import rtc_irq_pkg::*;

  logic                           tick_evt;
  logic                           alm_hit;
  logic [NUM_SRC-1:0]             src_evt;
  logic [NUM_SRC-1:0][BYTE_W-1:0] alarm_b;
  logic [NUM_SRC-1:0][BYTE_W-1:0] now_b;

  assign alarm_b = {alm_hr, alm_min, alm_sec};
  assign now_b   = {now_hr, now_min, now_sec};

  rtc_irq_prescaler #(.DIV_W(DIV_W), .RATE_W(RATE_W)) u_div (
    .clk(clk), .rst(rst), .osc_en(osc_en), .rate_sel(rate_sel),
    .sqw_en(sqw_en), .tick_evt(tick_evt), .sqw(sqw)
  );

  rtc_alarm_match #(.NF(NUM_SRC), .BW(BYTE_W)) u_alm (
    .alarm_b(alarm_b), .now_b(now_b), .hit(alm_hit)
  );

  always_comb begin
    src_evt          = '0;
    src_evt[SRC_PER] = tick_evt;
    src_evt[SRC_ALM] = upd_done & alm_hit;
    src_evt[SRC_UPD] = upd_done;
  end

  rtc_irq_flags #(.NSRC(NUM_SRC)) u_flg (
    .clk(clk), .rst(rst), .src_evt(src_evt), .mask(irq_mask),
    .clr(flag_rd), .flags(flags), .irq_n(irq_n)
  );
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk #(
  parameter int RATE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [RATE_W-1:0] rate_sel,
  input logic              sqw_en,
  input logic [2:0]        irq_mask,
  input logic              flag_rd,
  input logic              upd_done,
  input logic [2:0]        flags,
  input logic              irq_n,
  input logic              sqw
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (flags == 3'b000 && irq_n && !sqw));

  assert_no_tick_code0_R2: assert property (@(posedge clk) disable iff (rst)
    (rate_sel == '0 && !flags[0]) |=> !flags[0]);

  assert_sqw_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (!sqw_en || rate_sel == '0) |=> !sqw);

  assert_upd_sets_R6: assert property (@(posedge clk) disable iff (rst)
    upd_done |=> flags[2]);

  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n == !(|(flags & $past(irq_mask)))));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_rd && !upd_done) |=> (flags[2:1] == 2'b00));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!flag_rd && !upd_done) |=> $stable(flags[2:1]));
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst(rst), .rate_sel(rate_sel), .sqw_en(sqw_en),
  .irq_mask(irq_mask), .flag_rd(flag_rd), .upd_done(upd_done),
  .flags(flags), .irq_n(irq_n), .sqw(sqw)
);

// File: tb/tb_rtc_irq_ctrl.sv
`timescale 1ns/1ps
module tb_rtc_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_en = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       sqw_en = 1'b0;
  logic [2:0] irq_mask = 3'b000;
  logic       flag_rd = 1'b0;
  logic       upd_done = 1'b0;
  logic [7:0] now_sec = 8'h00, now_min = 8'h00, now_hr = 8'h00;
  logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hr = 8'h00;
  logic [2:0] flags;
  logic       irq_n;
  logic       sqw;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit model_on = 0;

  // model state
  int m_n = 0;
  int m_flags = 0;
  int m_irq = 1;
  int m_sqw = 0;

  always #2.5 clk = ~clk;

  rtc_irq_ctrl dut (
    .clk(clk), .rst(rst), .osc_en(osc_en), .rate_sel(rate_sel),
    .sqw_en(sqw_en), .irq_mask(irq_mask), .flag_rd(flag_rd),
    .upd_done(upd_done), .now_sec(now_sec), .now_min(now_min),
    .now_hr(now_hr), .alm_sec(alm_sec), .alm_min(alm_min),
    .alm_hr(alm_hr), .flags(flags), .irq_n(irq_n), .sqw(sqw)
  );

  function automatic bit byte_ok(input logic [7:0] a, input logic [7:0] t);
    return (a[7:6] == 2'b11) || (a == t);
  endfunction

  function automatic int eff_code(input int c);
    if (c == 1) return 8;
    if (c == 2) return 9;
    return c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on every edge
  always @(posedge clk) begin
    int c, e, nf;
    bit tick;
    if (rst) begin
      m_n = 0; m_flags = 0; m_irq = 1; m_sqw = 0;
    end else begin
      c = rate_sel;
      e = eff_code(c);
      tick = osc_en && c != 0 && (((m_n + 1) % (1 << (e - 1))) == 0);
      if (osc_en) m_n = (m_n + 1) % 32768;
      nf = flag_rd ? 0 : m_flags;
      if (tick) nf |= 1;
      if (upd_done) begin
        nf |= 4;
        if (byte_ok(alm_sec, now_sec) && byte_ok(alm_min, now_min) &&
            byte_ok(alm_hr, now_hr)) nf |= 2;
      end
      m_flags = nf;
      m_irq = ((nf & irq_mask) == 0) ? 1 : 0;
      m_sqw = (sqw_en && c != 0) ? ((m_n >> (e - 2)) & 1) : 0;
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      check("R2 periodic flag", flags[0], m_flags & 1);
      check("R5 alarm flag", flags[1], (m_flags >> 1) & 1);
      check("R6 update flag", flags[2], (m_flags >> 2) & 1);
      check("R7 irq_n", irq_n, m_irq);
      check("R4 sqw", sqw, m_sqw);
    end
  end

  task automatic tick_clk();
    @(posedge clk);
    #1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick_clk();
  endtask

  task automatic pulse_upd();
    upd_done = 1'b1;
    tick_clk();
    upd_done = 1'b0;
  endtask

  task automatic do_read();
    flag_rd = 1'b1;
    tick_clk();
    flag_rd = 1'b0;
  endtask

  initial begin
    int cnt;
    // R1: reset state
    run(3);
    check("R1 flags in reset", flags, 0);
    check("R1 irq_n in reset", irq_n, 1);
    check("R1 sqw in reset", sqw, 0);
    rst = 1'b0;
    model_on = 1;
    osc_en = 1'b1;

    // R2: fastest rate, then every code with reads in between
    rate_sel = 4'd3; irq_mask = 3'b001; sqw_en = 1'b1;
    run(40);
    do_read();
    for (int c = 4; c <= 15; c++) begin
      rate_sel = c[3:0];
      run((1 << (c - 1)) + 7);
      do_read();
    end

    // R3: count events at the aliased codes with a read every cycle
    flag_rd = 1'b1;
    rate_sel = 4'd1; cnt = 0;
    for (int i = 0; i < 1024; i++) begin tick_clk(); cnt += flags[0]; end
    check("R3 code1 events in 1024 strobes", cnt, 8);
    rate_sel = 4'd2; cnt = 0;
    for (int i = 0; i < 1024; i++) begin tick_clk(); cnt += flags[0]; end
    check("R3 code2 events in 1024 strobes", cnt, 4);
    rate_sel = 4'd0; cnt = 0;
    for (int i = 0; i < 600; i++) begin tick_clk(); cnt += flags[0]; end
    check("R2 code0 events", cnt, 0);
    flag_rd = 1'b0;

    // R4: irregular strobes, sqw disabled then enabled
    rate_sel = 4'd5;
    sqw_en = 1'b0;
    for (int i = 0; i < 90; i++) begin osc_en = (i % 3) == 0; tick_clk(); end
    check("R4 sqw disabled", sqw, 0);
    sqw_en = 1'b1;
    for (int i = 0; i < 300; i++) begin osc_en = (i % 3) != 1; tick_clk(); end
    osc_en = 1'b0; rate_sel = 4'd0;
    do_read();

    // R5: alarm patterns
    irq_mask = 3'b010;
    now_sec = 8'h30; now_min = 8'h15; now_hr = 8'h08;
    alm_sec = 8'h30; alm_min = 8'h15; alm_hr = 8'h08;
    pulse_upd();
    check("R5 exact match", flags[1], 1);
    check("R7 irq on alarm", irq_n, 0);
    do_read();
    check("R8 read clears", flags, 0);
    check("R8 irq released", irq_n, 1);
    alm_min = 8'h16;
    pulse_upd();
    check("R5 minute mismatch", flags[1], 0);
    do_read();
    alm_min = 8'hC0;
    pulse_upd();
    check("R5 minute wildcard", flags[1], 1);
    do_read();
    alm_sec = 8'hFF; alm_hr = 8'hC5; now_sec = 8'h59;
    pulse_upd();
    check("R5 all wildcard", flags[1], 1);
    do_read();
    alm_hr = 8'h80;
    pulse_upd();
    check("R5 top bit only not wildcard", flags[1], 0);
    do_read();

    // R10: matching bytes without an update pulse
    alm_hr = 8'h08;
    run(5);
    check("R10 no compare without update", flags[2:1], 0);

    // R8: event in the read cycle survives
    flag_rd = 1'b1; upd_done = 1'b1;
    tick_clk();
    flag_rd = 1'b0; upd_done = 1'b0;
    check("R8 update during read kept", flags[2], 1);
    do_read();

    // R9: masked flag still sets, irq stays high
    irq_mask = 3'b000;
    pulse_upd();
    check("R9 masked flag set", flags[2], 1);
    check("R9 masked irq high", irq_n, 1);
    irq_mask = 3'b100;
    tick_clk();
    check("R7 mask enable asserts irq", irq_n, 0);
    do_read();
    check("R7 irq after read", irq_n, 1);

    // reset mid-run
    osc_en = 1'b1; rate_sel = 4'd3; irq_mask = 3'b111;
    run(10);
    pulse_upd();
    rst = 1'b1;
    tick_clk();
    check("R1 flags after late reset", flags, 0);
    check("R1 irq_n after late reset", irq_n, 1);
    rst = 1'b0;
    run(50);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule